// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block keeps an SDRAM's contents alive on behalf of a memory controller. A free-running interval counter earns one refresh credit every `REF_INTERVAL` clocks. The default is the 64 ms retention window divided by 4096 rows at a 200 MHz clock. While any credit is owed, the block raises `ref_req` toward the access sequencer and waits for `ref_gnt`. A request that is held off keeps its credits, up to `MAX_CREDIT`, so an access in flight can finish first. Once granted, the block owns the command bus. It closes all open rows with a precharge-all, issues one auto refresh `T_RP` clocks later, and holds `busy` until `T_RC` clocks after that refresh.

The same request/grant pair carries sleep. While `sleep_req` is high, a granted slot becomes a self-refresh entry: precharge-all, then the entry command with `cke` dropped low. `cke` stays low for at least `T_RAS` clocks and for as long as `sleep_req` stays high. When `sleep_req` falls, the block raises `cke` and keeps the bus idle for a two-clock NOP guard plus `T_RC`. It then issues `CATCHUP_N` auto refreshes spaced `T_RC` apart, because the device's internal row pointer is unknown after self-refresh.

The request/grant pair is a valid/ready handshake with back-pressure from the sequencer. `ref_req` stays high until it is granted, and holding back `ref_gnt` only defers the work. The grant is taken in the cycle where both are high. The address and bank lines are don't-care for every command this block strobes, so it drives none of them.

Top module: `sdram_refresh_sched`

## Requirements
- R1: The interval counter runs from reset and earns one credit every `REF_INTERVAL` clocks. With `ref_gnt` held high, successive auto refresh strobes outside sleep are exactly `REF_INTERVAL` clocks apart.
- R2: No command strobe appears unless `ref_req` and `ref_gnt` were both high in the previous clock. `ref_req` is high only while idle with a credit owed or `sleep_req` high. It stays high until granted and is low once nothing is owed.
- R3: A granted refresh strobes `pre_all_stb` for one clock, then `aref_stb` exactly `T_RP` clocks later. `busy` is high from the clock after the grant until `T_RC` clocks after the refresh strobe, and at most one strobe is high in any clock.
- R4: Up to `MAX_CREDIT` credits accumulate while the grant is withheld, and extra credits are dropped. When granted, exactly that many refreshes run back to back, and afterwards `ref_req` is low.
- R5: A grant taken while `sleep_req` is high strobes `pre_all_stb`, then `sref_stb` `T_RP` clocks later, with `cke` going low in that same clock. `cke` stays low for at least `T_RAS` clocks even if `sleep_req` falls early.
- R6: After `sleep_req` falls, `cke` rises and no strobe appears for `2 + T_RC` clocks. The first catch-up refresh strobe comes exactly `2 + T_RC` clocks after `cke` rose.
- R7: The catch-up burst is exactly `CATCHUP_N` `aref_stb` pulses, each `T_RC` after the previous one, with no precharge and no grant needed. `busy` falls `T_RC` after the last pulse.
- R8: After reset `cke` is 1 and `busy`, `ref_req` and all strobes are 0. `cke` is high at every auto refresh strobe, and `ref_req` is never high while `busy` is.
- R9: The catch-up burst clears all credits and restarts the interval counter. With nothing else owed, `ref_req` next rises exactly `REF_INTERVAL` clocks after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Level: high asks for self-refresh, low asks to wake |
| ref_gnt | input | 1 | Grant (ready) from the access sequencer |
| ref_req | output | 1 | Request (valid) for the command bus |
| cke | output | 1 | Clock-enable level for the SDRAM |
| pre_all_stb | output | 1 | One-clock precharge-all command strobe |
| aref_stb | output | 1 | One-clock auto refresh command strobe |
| sref_stb | output | 1 | One-clock self-refresh entry command strobe |
| busy | output | 1 | Command bus held by this block |

## Verification
A wrong wait count shows up as a strobe that is one or more clocks off its fixed distance from the preceding strobe or from the `cke` edge. This becomes visible within `T_RP`, `T_RC` or `T_RAS` clocks. A miscounted credit shows up as one extra or one missing refresh in the back-to-back drain after a withheld grant, or as `ref_req` still high when the drain ends. A catch-up counter off by one gives the wrong number of refresh pulses before `busy` falls. An interval counter that was not restarted moves the next `ref_req` away from exactly `REF_INTERVAL` clocks after wake.

// File: rtl/sdram_refsched_pkg.sv
`timescale 1ns/1ps
package sdram_refsched_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,   // waiting for credit or sleep plus grant
    ST_PRE,    // precharge-all strobe
    ST_RP,     // precharge recovery
    ST_AREF,   // periodic auto refresh strobe
    ST_RC,     // refresh cycle time
    ST_SRE,    // self-refresh entry strobe, cke low
    ST_HOLD,   // minimum cke-low time
    ST_SLEEP,  // device in self-refresh
    ST_NOP,    // NOP guard after cke rises
    ST_REC,    // exit recovery
    ST_CAREF,  // catch-up refresh strobe
    ST_CWAIT   // catch-up spacing
  } sched_state_t;
endpackage

// File: rtl/refsched_credit.sv
`timescale 1ns/1ps
module refsched_credit #(
  parameter int REF_INTERVAL = 3125,
  parameter int MAX_CREDIT   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic consume,
  output logic owed
);
  localparam int IW = $clog2(REF_INTERVAL);
  localparam int CW = $clog2(MAX_CREDIT + 1);

  logic [IW-1:0] icnt;
  logic [CW-1:0] credits;
  logic          tick;

  assign tick = (icnt == IW'(REF_INTERVAL - 1));
  assign owed = (credits != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      icnt    <= '0;
      credits <= '0;
    end else begin
      icnt <= tick ? '0 : icnt + IW'(1);
      if (tick && !consume) begin
        if (credits != CW'(MAX_CREDIT)) credits <= credits + CW'(1);
      end else if (!tick && consume) begin
        credits <= credits - CW'(1);
      end
    end
  end

  assert_credit_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    credits <= CW'(MAX_CREDIT));
  assert_consume_owed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    consume |-> credits != '0);
endmodule

// File: rtl/refsched_fsm.sv
`timescale 1ns/1ps
module refsched_fsm
  import sdram_refsched_pkg::*;
#(
  parameter int T_RP      = 4,
  parameter int T_RC      = 13,
  parameter int T_RAS     = 9,
  parameter int NOP_GUARD = 2,
  parameter int CATCHUP_N = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic owed,
  input  logic sleep_req,
  input  logic ref_gnt,
  output logic ref_req,
  output logic pre_all_stb,
  output logic aref_stb,
  output logic sref_stb,
  output logic cke,
  output logic busy,
  output logic hold,
  output logic consume
);
  localparam int M1   = (T_RP > T_RC) ? T_RP : T_RC;
  localparam int M2   = (T_RAS > NOP_GUARD) ? T_RAS : NOP_GUARD;
  localparam int WMAX = (M1 > M2) ? M1 : M2;
  localparam int WW   = $clog2(WMAX + 1);
  localparam int RW   = $clog2(CATCHUP_N + 1);

  sched_state_t  state;
  logic [WW-1:0] wcnt;
  logic [RW-1:0] rem;
  logic          sr_mode;

  assign ref_req     = (state == ST_IDLE) && (owed || sleep_req);
  assign pre_all_stb = (state == ST_PRE);
  assign aref_stb    = (state == ST_AREF) || (state == ST_CAREF);
  assign sref_stb    = (state == ST_SRE);
  assign cke         = !(state inside {ST_SRE, ST_HOLD, ST_SLEEP});
  assign busy        = (state != ST_IDLE);
  assign hold        = sr_mode;
  assign consume     = (state == ST_AREF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      wcnt    <= '0;
      rem     <= '0;
      sr_mode <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (ref_req && ref_gnt) begin
          state   <= ST_PRE;
          sr_mode <= sleep_req;
        end
        ST_PRE: begin
          state <= ST_RP;
          wcnt  <= WW'(T_RP - 2);
        end
        ST_RP: if (wcnt == '0) state <= sr_mode ? ST_SRE : ST_AREF;
               else wcnt <= wcnt - WW'(1);
        ST_AREF: begin
          state <= ST_RC;
          wcnt  <= WW'(T_RC - 2);
        end
        ST_RC: if (wcnt == '0) state <= ST_IDLE;
               else wcnt <= wcnt - WW'(1);
        ST_SRE: begin
          state <= ST_HOLD;
          wcnt  <= WW'(T_RAS - 2);
        end
        ST_HOLD: if (wcnt == '0) state <= ST_SLEEP;
                 else wcnt <= wcnt - WW'(1);
        ST_SLEEP: if (!sleep_req) begin
          state <= ST_NOP;
          wcnt  <= WW'(NOP_GUARD - 1);
        end
        ST_NOP: if (wcnt == '0) begin
          state <= ST_REC;
          wcnt  <= WW'(T_RC - 1);
          rem   <= RW'(CATCHUP_N - 1);
        end else wcnt <= wcnt - WW'(1);
        ST_REC: if (wcnt == '0) state <= ST_CAREF;
                else wcnt <= wcnt - WW'(1);
        ST_CAREF: begin
          state <= ST_CWAIT;
          wcnt  <= WW'(T_RC - 2);
        end
        ST_CWAIT: if (wcnt != '0) wcnt <= wcnt - WW'(1);
          else if (rem == '0) begin
            state   <= ST_IDLE;
            sr_mode <= 1'b0;
          end else begin
            rem   <= rem - RW'(1);
            state <= ST_CAREF;
          end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // cke-low run length, kept for the minimum-hold check
  int lowcnt;
  always_ff @(posedge clk) begin
    if (!rst_n || cke) lowcnt <= 0;
    else if (lowcnt < T_RAS) lowcnt <= lowcnt + 1;
  end

  assert_grant_before_pre_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pre_all_stb |-> $past(ref_req && ref_gnt));
  assert_strobe_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pre_all_stb, aref_stb, sref_stb}));
  assert_cke_low_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> lowcnt >= T_RAS);
  assert_aref_cke_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    aref_stb |-> cke);
  assert_no_req_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ref_req);
endmodule

// File: rtl/sdram_refresh_sched.sv
`timescale 1ns/1ps
module sdram_refresh_sched #(
  parameter int REF_INTERVAL = 3125,
  parameter int MAX_CREDIT   = 8,
  parameter int T_RP         = 4,
  parameter int T_RC         = 13,
  parameter int T_RAS        = 9,
  parameter int NOP_GUARD    = 2,
  parameter int CATCHUP_N    = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic ref_gnt,
  output logic ref_req,
  output logic cke,
  output logic pre_all_stb,
  output logic aref_stb,
  output logic sref_stb,
  output logic busy
);
  logic owed, hold, consume;

  refsched_credit #(
    .REF_INTERVAL(REF_INTERVAL),
    .MAX_CREDIT  (MAX_CREDIT)
  ) u_credit (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (hold),
    .consume(consume),
    .owed   (owed)
  );

  refsched_fsm #(
    .T_RP     (T_RP),
    .T_RC     (T_RC),
    .T_RAS    (T_RAS),
    .NOP_GUARD(NOP_GUARD),
    .CATCHUP_N(CATCHUP_N)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .owed       (owed),
    .sleep_req  (sleep_req),
    .ref_gnt    (ref_gnt),
    .ref_req    (ref_req),
    .pre_all_stb(pre_all_stb),
    .aref_stb   (aref_stb),
    .sref_stb   (sref_stb),
    .cke        (cke),
    .busy       (busy),
    .hold       (hold),
    .consume    (consume)
  );
endmodule

// File: tb/sdram_refresh_sched_tb.sv
`timescale 1ns/1ps
module sdram_refresh_sched_tb;
  localparam int INT  = 100;
  localparam int MAXC = 4;
  localparam int TRP  = 3;
  localparam int TRC  = 6;
  localparam int TRAS = 5;
  localparam int NCU  = 4;
  localparam int K_PRE = 1, K_AREF = 2, K_SRE = 3, K_WAKE = 4;

  logic clk = 1'b0, rst_n = 1'b0, sleep_req = 1'b0, ref_gnt = 1'b1;
  logic ref_req, cke, pre_all_stb, aref_stb, sref_stb, busy;

  always #2.5 clk = ~clk;

  sdram_refresh_sched #(
    .REF_INTERVAL(INT), .MAX_CREDIT(MAXC), .T_RP(TRP), .T_RC(TRC),
    .T_RAS(TRAS), .NOP_GUARD(2), .CATCHUP_N(NCU)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .ref_gnt(ref_gnt),
    .ref_req(ref_req), .cke(cke), .pre_all_stb(pre_all_stb),
    .aref_stb(aref_stb), .sref_stb(sref_stb), .busy(busy)
  );

  int nchk = 0, nerr = 0;
  int exp_q[$];
  int cyc = 0, last_kind = 0, last_pre = 0, last_sre = 0, last_wake = 0;
  int last_aref = 0, last_norm = -1, n_aref = 0;
  bit catch_mode = 0, phase_a = 0, done = 0, prev_cke = 1, prev_busy = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // driver side of the scoreboard
  task automatic expect_ev(input int kind);
    exp_q.push_back(kind);
  endtask

  task automatic take(input int kind);
    if (exp_q.size() == 0) check(1'b0, "R2", "unexpected strobe", kind, 0);
    else begin
      int e;
      e = exp_q.pop_front();
      check(e == kind, "R7", "event order", kind, e);
    end
  endtask

  // monitor side
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (cke && !prev_cke) begin
        take(K_WAKE);
        check(cyc - last_sre >= TRAS, "R5", "cke low time", cyc - last_sre, TRAS);
        last_wake = cyc; last_kind = K_WAKE; catch_mode = 1;
      end
      if (pre_all_stb) begin
        take(K_PRE);
        last_pre = cyc; last_kind = K_PRE; catch_mode = 0;
      end
      if (sref_stb) begin
        take(K_SRE);
        check(cyc - last_pre == TRP, "R5", "pre to entry gap", cyc - last_pre, TRP);
        check(cke == 1'b0, "R5", "cke at entry", int'(cke), 0);
        last_sre = cyc; last_kind = K_SRE;
      end
      if (aref_stb) begin
        take(K_AREF);
        check(cke == 1'b1, "R8", "cke at refresh", int'(cke), 1);
        if (last_kind == K_PRE)
          check(cyc - last_pre == TRP, "R3", "pre to refresh gap", cyc - last_pre, TRP);
        else if (last_kind == K_WAKE)
          check(cyc - last_wake == 2 + TRC, "R6", "wake to first refresh", cyc - last_wake, 2 + TRC);
        else if (last_kind == K_AREF && catch_mode)
          check(cyc - last_aref == TRC, "R7", "catch-up spacing", cyc - last_aref, TRC);
        if (phase_a && last_norm >= 0)
          check(cyc - last_norm == INT, "R1", "refresh period", cyc - last_norm, INT);
        if (!catch_mode) last_norm = cyc;
        last_aref = cyc; last_kind = K_AREF; n_aref++;
      end
      if (prev_busy && !busy && last_kind == K_AREF)
        check(cyc - last_aref == TRC, "R3", "busy release after refresh", cyc - last_aref, TRC);
      prev_cke = cke; prev_busy = busy;
    end
  end

  task automatic wait_req_rise();
    while (ref_req) @(negedge clk);
    while (!ref_req) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic drain(input int k, input string tag);
    for (int i = 0; i < k; i++) begin expect_ev(K_PRE); expect_ev(K_AREF); end
    ref_gnt = 1'b1;
    repeat (k * 10 + 15) @(negedge clk);
    ref_gnt = 1'b0;
    check(exp_q.size() == 0, tag, "refreshes left undone", exp_q.size(), 0);
    check(ref_req == 1'b0, tag, "request after drain", int'(ref_req), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cke == 1'b1, "R8", "reset cke", int'(cke), 1);
    check(busy == 1'b0, "R8", "reset busy", int'(busy), 0);
    check(ref_req == 1'b0, "R8", "reset request", int'(ref_req), 0);
    check({pre_all_stb, aref_stb, sref_stb} == 3'b000, "R8", "reset strobes",
          int'({pre_all_stb, aref_stb, sref_stb}), 0);

    // R1: steady periodic refresh with grant always given
    phase_a = 1;
    for (int i = 0; i < 3; i++) begin expect_ev(K_PRE); expect_ev(K_AREF); end
    while (n_aref < 3) @(negedge clk);
    ref_gnt = 1'b0;
    phase_a = 0;
    wait_idle();
    check(exp_q.size() == 0, "R1", "periodic refreshes missing", exp_q.size(), 0);

    // R2 and R4: withheld grant, three credits, then back-to-back drain
    wait_req_rise();
    repeat (10) @(negedge clk);
    check(busy == 1'b0, "R2", "busy without grant", int'(busy), 0);
    check(ref_req == 1'b1, "R2", "request held", int'(ref_req), 1);
    repeat (2 * INT - 5) @(negedge clk);
    drain(3, "R4");

    // R4: saturation at MAX_CREDIT
    wait_req_rise();
    repeat (6 * INT + 5) @(negedge clk);
    drain(MAXC, "R4");

    // R5, R6, R7: long self-refresh
    expect_ev(K_PRE); expect_ev(K_SRE);
    sleep_req = 1'b1; ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
    repeat (30) @(negedge clk);
    check(cke == 1'b0, "R5", "cke while asleep", int'(cke), 0);
    check(busy == 1'b1, "R5", "busy while asleep", int'(busy), 1);
    check(exp_q.size() == 0, "R5", "entry sequence incomplete", exp_q.size(), 0);
    expect_ev(K_WAKE);
    for (int i = 0; i < NCU; i++) expect_ev(K_AREF);
    sleep_req = 1'b0;
    @(negedge clk);
    wait_idle();
    check(exp_q.size() == 0, "R7", "catch-up count short", exp_q.size(), 0);

    // R9: interval restarted after catch-up
    begin
      int n;
      n = 0;
      while (!ref_req && n < 3 * INT) begin @(negedge clk); n++; end
      check(n == INT, "R9", "first request after wake", n, INT);
    end

    // R5: short sleep, cke still held low for the minimum
    expect_ev(K_PRE); expect_ev(K_SRE); expect_ev(K_WAKE);
    for (int i = 0; i < NCU; i++) expect_ev(K_AREF);
    sleep_req = 1'b1; ref_gnt = 1'b1;
    while (!sref_stb) @(negedge clk);
    sleep_req = 1'b0; ref_gnt = 1'b0;
    @(negedge clk);
    wait_idle();
    check(exp_q.size() == 0, "R6", "short sleep sequence", exp_q.size(), 0);
    check(ref_req == 1'b0, "R9", "credits cleared after wake", int'(ref_req), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule